// File: doc/BRIEF.md
# Push-Pull Pulse Steering Logic

This block sits between a PWM comparator and the two drivers of a push-pull switching controller. Every input arrives as a clean digital level, synchronous to a fast system clock: the raw comparator result, an active-low shutdown or current-limit input, an oscillator sync pulse, a deadtime blanking pulse and an undervoltage inhibit. The block sends each permitted pulse to one of two driver outputs, and the two outputs take turns.

A metering state machine lets the gated PWM signal through once for each oscillator cycle. A rising edge of sync arms it. After the pulse it passed has ended, it stays closed until the next sync edge. A memory bit records whether the cycle produced a pulse. The steering toggle advances at the next sync edge only when that bit is set, so a cycle without a pulse can never cause two pulses in a row on one driver. A parameter selects the output polarity: active-high, or active-low.

Metering states: `MT_IDLE` (not yet armed after reset), `MT_ARMED` (waiting for a pulse), `MT_PASS` (pulse being passed), `MT_SPENT` (pulse finished, closed until the next sync). Transitions: any state goes to `MT_ARMED` on a sync rising edge, and this transition has priority over the others. `MT_ARMED` goes to `MT_PASS` when the gated PWM signal is high. `MT_PASS` goes to `MT_SPENT` when the gated PWM signal is low. Every other case holds the current state.

Top module: `pp_pulse_steer`

## Requirements
- R1: The gated PWM signal is the comparator input ANDed with the shutdown input. While the shutdown input is low, no pulse can start.
- R2: Only a rising edge on sync arms the metering logic. After reset, no pulse appears before the first sync edge. While the block is armed, a high gated PWM level makes the pulse active one clock later.
- R3: Once a passed pulse has ended (one clock after the gated PWM signal goes low), no further pulse appears until the next sync rising edge, even if the gated PWM signal goes high again.
- R4: At a sync rising edge, the steering toggle inverts only if a pulse was active at some point since the previous sync edge. Otherwise it keeps its value.
- R5: The pulse goes to output A while the toggle is 0 and to output B while it is 1. The two outputs are never active together.
- R6: While the blanking input is high, both outputs are inactive.
- R7: While the undervoltage inhibit is high, both outputs are inactive.
- R8: With ACTIVE_LOW=0 an active output is 1 and an inactive output is 0. With ACTIVE_LOW=1 both levels are inverted.
- R9: After reset, both outputs are inactive, the toggle is 0 (output A goes first) and the memory bit is clear.
- R10: A sync input that stays high for several clocks arms the block only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_cmp | input | 1 | Raw PWM comparator result |
| shdn_n | input | 1 | Shutdown / current limit, low blocks pulses |
| osc_sync | input | 1 | Oscillator sync pulse, rising edge starts a cycle |
| dead_blank | input | 1 | Deadtime blanking pulse |
| uv_inhibit | input | 1 | Undervoltage inhibit |
| drv_a | output | 1 | Driver A output |
| drv_b | output | 1 | Driver B output |

## Verification
The bench builds two instances that share every input. One uses the default ACTIVE_LOW=0 and the other uses ACTIVE_LOW=1, so each output level is checked in both polarities on the same stimulus. Directed steps cover the cases that random stimulus rarely reaches: a held sync, a second PWM crossing within one cycle, a cycle with no pulse that must leave the toggle unchanged, and shutdown chopping. Randomised sync periods, sync lengths and chopping then exercise the interaction between metering and steering over many cycles.

// File: rtl/pps_pkg.sv
package pps_pkg;
    typedef enum logic [1:0] {
        MT_IDLE  = 2'd0,
        MT_ARMED = 2'd1,
        MT_PASS  = 2'd2,
        MT_SPENT = 2'd3
    } meter_t;
endpackage

// File: rtl/pps_edge.sv
module pps_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise_out
);
    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_in;
    end

    assign rise_out = level_in & ~level_q;

    // R10
    no_double_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_out |=> !rise_out);
endmodule

// File: rtl/pps_meter.sv
module pps_meter
    import pps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic gated,
    output logic pulse
);
    meter_t state, state_nx;

    always_comb begin
        state_nx = state;
        if (arm) begin
            state_nx = MT_ARMED;
        end else begin
            unique case (state)
                MT_IDLE:  state_nx = MT_IDLE;
                MT_ARMED: if (gated)  state_nx = MT_PASS;
                MT_PASS:  if (!gated) state_nx = MT_SPENT;
                MT_SPENT: state_nx = MT_SPENT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MT_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        pulse = (state == MT_PASS);
    end

    // R3
    no_second_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MT_SPENT && !arm) |=> !pulse);
    // R1
    gate_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MT_ARMED && !gated && !arm) |=> !pulse);
endmodule

// File: rtl/pps_steer.sv
module pps_steer (
    input  logic clk,
    input  logic rst_n,
    input  logic cycle_start,
    input  logic pulse,
    output logic sel_b
);
    logic fired;
    logic fired_eff;

    assign fired_eff = fired | pulse;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fired <= 1'b0;
            sel_b <= 1'b0;
        end else if (cycle_start) begin
            fired <= 1'b0;
            if (fired_eff) sel_b <= ~sel_b;
        end else begin
            fired <= fired_eff;
        end
    end

    // R4
    hold_without_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_start && !fired && !pulse) |=> $stable(sel_b));
    // R4
    advance_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_start && fired) |=> (sel_b != $past(sel_b)));
endmodule

// File: rtl/pp_pulse_steer.sv
module pp_pulse_steer #(
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_cmp,
    input  logic shdn_n,
    input  logic osc_sync,
    input  logic dead_blank,
    input  logic uv_inhibit,
    output logic drv_a,
    output logic drv_b
);
    logic cycle_start;
    logic gated;
    logic pulse;
    logic sel_b;
    logic act_a, act_b;
    logic enable;

    assign gated = pwm_cmp & shdn_n;

    pps_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (osc_sync),
        .rise_out (cycle_start)
    );

    pps_meter u_meter (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (cycle_start),
        .gated (gated),
        .pulse (pulse)
    );

    pps_steer u_steer (
        .clk         (clk),
        .rst_n       (rst_n),
        .cycle_start (cycle_start),
        .pulse       (pulse),
        .sel_b       (sel_b)
    );

    assign enable = ~dead_blank & ~uv_inhibit;
    assign act_a  = ~(~pulse | dead_blank | uv_inhibit | sel_b);
    assign act_b  = pulse & enable & sel_b;

    generate
        if (ACTIVE_LOW) begin : g_low
            assign drv_a = ~act_a;
            assign drv_b = ~act_b;
        end else begin : g_high
            assign drv_a = act_a;
            assign drv_b = act_b;
        end
    endgenerate

    // R5
    never_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act_a, act_b}));
    // R7
    uv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uv_inhibit |-> (drv_a == ACTIVE_LOW && drv_b == ACTIVE_LOW));
    // R6
    blank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dead_blank |-> (drv_a == ACTIVE_LOW && drv_b == ACTIVE_LOW));
endmodule

// File: tb/sim_pp_pulse_steer.sv
`timescale 1ns/1ps
module sim_pp_pulse_steer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_cmp = 1'b0, shdn_n = 1'b1, osc_sync = 1'b0;
    logic dead_blank = 1'b0, uv_inhibit = 1'b0;
    logic a_hi, b_hi, a_lo, b_lo;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state
    int  m_state = 0;   // 0 idle, 1 armed, 2 passing, 3 spent
    bit  m_prev = 1'b0;
    bit  m_fired = 1'b0;
    bit  m_tog = 1'b0;

    always #2.5 clk = ~clk;

    pp_pulse_steer #(.ACTIVE_LOW(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .pwm_cmp(pwm_cmp), .shdn_n(shdn_n),
        .osc_sync(osc_sync), .dead_blank(dead_blank), .uv_inhibit(uv_inhibit),
        .drv_a(a_hi), .drv_b(b_hi));

    pp_pulse_steer #(.ACTIVE_LOW(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .pwm_cmp(pwm_cmp), .shdn_n(shdn_n),
        .osc_sync(osc_sync), .dead_blank(dead_blank), .uv_inhibit(uv_inhibit),
        .drv_a(a_lo), .drv_b(b_lo));

    function automatic bit exp_act(input bit side_b);
        return (m_state == 2) && !dead_blank && !uv_inhibit && (m_tog == side_b);
    endfunction

    task automatic check_now(input string tag);
        bit ea, eb;
        ea = exp_act(1'b0);
        eb = exp_act(1'b1);
        checks++;
        if (a_hi !== ea || b_hi !== eb) begin
            failures++;
            $display("FAIL %s high-pol a/b actual=%b%b expected=%b%b t=%0t", tag, a_hi, b_hi, ea, eb, $time);
        end
        checks++;
        if (a_lo !== ~ea || b_lo !== ~eb) begin
            failures++;
            $display("FAIL %s R8 low-pol a/b actual=%b%b expected=%b%b t=%0t", tag, a_lo, b_lo, ~ea, ~eb, $time);
        end
    endtask

    task automatic model_update();
        bit rise, g, fe;
        rise = osc_sync && !m_prev;
        g = pwm_cmp && shdn_n;
        fe = m_fired || (m_state == 2);
        if (rise) begin
            if (fe) m_tog = ~m_tog;
            m_fired = 1'b0;
            m_state = 1;
        end else begin
            m_fired = fe;
            if (m_state == 1 && g) m_state = 2;
            else if (m_state == 2 && !g) m_state = 3;
        end
        m_prev = osc_sync;
    endtask

    task automatic step(input bit sy, input bit pw, input bit sd,
                        input bit bl, input bit uv, input string tag);
        @(negedge clk);
        osc_sync = sy; pwm_cmp = pw; shdn_n = sd; dead_blank = bl; uv_inhibit = uv;
        #1;
        check_now(tag);
        model_update();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        #1;
        check_now("R9");
        rst_n = 1'b1;

        // R2: no pulse before first sync, even with PWM high
        step(0,1,1,0,0,"R2");
        step(0,1,1,0,0,"R2");
        // R2: arm, pulse on A first (R9)
        step(1,0,1,0,0,"R2");
        step(0,1,1,0,0,"R2");
        step(0,1,1,0,0,"R9");
        step(0,1,1,0,0,"R9");
        // R3: end pulse, second crossing blocked
        step(0,0,1,0,0,"R3");
        step(0,0,1,0,0,"R3");
        step(0,1,1,0,0,"R3");
        step(0,1,1,0,0,"R3");
        step(0,0,1,0,0,"R3");
        // R10: long sync arms once, toggle -> B
        step(1,0,1,0,0,"R10");
        step(1,0,1,0,0,"R10");
        step(1,0,1,0,0,"R10");
        step(0,1,1,0,0,"R10");
        step(0,1,1,0,0,"R5");
        step(0,0,1,0,0,"R5");
        // held sync must not re-arm
        step(1,0,1,0,0,"R10");
        step(1,1,1,0,0,"R10");
        step(1,1,1,0,0,"R10");
        step(1,0,1,0,0,"R10");
        step(1,1,1,0,0,"R10");
        step(0,0,1,0,0,"R10");
        // R1: shutdown low blocks whole cycle
        step(1,0,1,0,0,"R1");
        step(0,1,0,0,0,"R1");
        step(0,1,0,0,0,"R1");
        step(0,0,0,0,0,"R1");
        // R4: no pulse in previous cycle -> toggle stays
        step(1,0,1,0,0,"R4");
        step(0,1,1,0,0,"R4");
        step(0,1,1,0,0,"R4");
        // R1: shutdown chop ends pulse, chop release no new pulse (R3)
        step(0,1,0,0,0,"R1");
        step(0,1,1,0,0,"R3");
        step(0,1,1,0,0,"R3");
        // R6 / R7
        step(1,0,1,0,0,"R6");
        step(0,1,1,0,0,"R6");
        step(0,1,1,1,0,"R6");
        step(0,1,1,0,0,"R6");
        step(0,1,1,0,1,"R7");
        step(0,1,1,0,0,"R7");
        step(0,0,1,0,0,"R7");

        // random phase
        for (int cyc = 0; cyc < 400; cyc++) begin
            int period, slen, blen;
            period = 12 + ($urandom % 20);
            slen = 1 + ($urandom % 3);
            blen = $urandom % 3;
            for (int t = 0; t < period; t++) begin
                bit sy, pw, sd, bl, uv;
                sy = (t < slen);
                bl = (t < blen);
                pw = ($urandom % 4) != 0 && (t > 2) && (t < period - 3 - ($urandom % 6));
                sd = ($urandom % 10) != 0;
                uv = ($urandom % 50) == 0;
                step(sy, pw, sd, bl, uv, "R4/R5");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule